// File: doc/BRIEF.md
# Dual-Source Interrupt Down-Counter

This block produces a timed interrupt request for a cartridge controller. An 8-bit down-counter is advanced by one of two selectable sources. The first is a pre-filtered pulse that marks a rising edge of the video address bit being watched. The second is a divide-by-4 prescaler driven by the CPU cycle enable. When a counter step leaves the counter at zero while the interrupt is enabled, the request output goes high after a short delay counted in CPU cycles. The output then stays high until software acknowledges it.

Software reaches the block through a plain write bus. The address is masked before decoding, so each function answers across a mirrored range. The functions are: store a reload value; pick the clock source and request a reload; acknowledge and disable; enable. Banking and the filtering of the address-bit edges sit outside this block.

Top module: `dual_src_irq_counter`

## Requirements
- R1: After reset the request output `irq` is low. The counter, the reload value, the enable and every internal flag are zero, and the block starts in edge-clocked mode.
- R2: A write is decoded on `wr_addr & 0xE001`. 0xC000 stores `wr_data` as the reload value. 0xC001 requests a reload and sets the mode to `wr_data[0]` (1 = CPU-cycle clocking). 0xE000 disables and acknowledges. 0xE001 enables. Mirrors such as 0xC0FE (reload) and 0xFFFE (acknowledge) behave the same.
- R3: On a counter step with a reload request pending, the counter is first loaded with the reload value r plus 1 (if r <= 1) or plus 2 (otherwise), using 8-bit wrap, and the request clears. The counter then decrements. So the first zero comes on step 1 for r=0, step 2 for r=1, step 256 for r=254, step 1 for r=255, and step r+2 for any other r.
- R4: On a step with no request pending, a counter at zero reloads to r+1 before the decrement. A free-running counter therefore reaches zero every r+1 steps (every 256 steps for r=255).
- R5: A zero reached on an edge step raises `irq` 2 CPU cycles later. A zero reached on a prescaler step raises it 1 CPU cycle later. The delay is counted in cycles with `cpu_ce` high, and the step's own cycle is not counted.
- R6: In CPU-cycle mode the prescaler advances once per `cpu_ce` and steps the counter on every 4th advance. Entering the mode clears the prescaler. Edge pulses are ignored in this mode.
- R7: Writing 0 to the mode address while in CPU-cycle mode leaves that mode but arms exactly one more prescaler step. The prescaler keeps running until that step and then stops.
- R8: A zero reached while the interrupt is disabled schedules no request.
- R9: `irq` stays high until an acknowledge write. An acknowledge in the same cycle as a delay expiry leaves `irq` low. A delay already running when a disable is written still raises `irq`.
- R10: A prescaler step and an edge step in the same cycle both step the counter, the prescaler step first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_ce | input | 1 | One-cycle enable marking a CPU cycle |
| vaddr_rise | input | 1 | Pre-filtered rising-edge pulse of the watched video address bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address, masked before decoding |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Active-high interrupt request, held until acknowledged |

## Verification
The armed extra prescaler step after leaving CPU-cycle mode can fall in the same cycle as an edge pulse, which is now accepted. The bench arms that step from a reload of 3 and places an edge pulse on the wrap cycle. It then counts the edges still needed before the request: three edges are needed if both steps were taken, and four if one was lost. A second collision, an acknowledge written in the cycle a pending delay expires, is provoked and judged by `irq` staying low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    WK_NONE,
    WK_RELOAD,
    WK_MODE,
    WK_DISABLE,
    WK_ENABLE
  } wr_kind_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] DEC_MASK = 16'hE001,
  parameter logic [ADDR_W-1:0] A_RELOAD = 16'hC000,
  parameter logic [ADDR_W-1:0] A_MODE   = 16'hC001,
  parameter logic [ADDR_W-1:0] A_DIS    = 16'hE000,
  parameter logic [ADDR_W-1:0] A_EN     = 16'hE001
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_kind_e          kind
);
  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked = wr_addr & DEC_MASK;
    kind   = WK_NONE;
    if (wr_en) begin
      if      (masked == A_RELOAD) kind = WK_RELOAD;
      else if (masked == A_MODE)   kind = WK_MODE;
      else if (masked == A_DIS)    kind = WK_DISABLE;
      else if (masked == A_EN)     kind = WK_ENABLE;
    end
  end
endmodule

// File: rtl/irqc_prescale.sv
module irqc_prescale #(
  parameter int PRE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ce,
  input  logic wr_mode,
  input  logic wr_bit0,
  output logic mode_q,
  output logic tick
);
  logic [PRE_W-1:0] pre_q, pre_d, pre_inc;
  logic             force_q, force_d, mode_d, run;

  always_comb begin
    run     = cpu_ce & (mode_q | force_q);
    pre_inc = pre_q + PRE_W'(1);
    tick    = run & (pre_inc == '0);
    pre_d   = run ? pre_inc : pre_q;
    force_d = tick ? 1'b0 : force_q;
    mode_d  = mode_q;
    if (wr_mode) begin
      if (mode_q && !wr_bit0) force_d = 1'b1;
      mode_d = wr_bit0;
      if (wr_bit0) pre_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      force_q <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      force_q <= force_d;
      mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/irqc_counter.sv
module irqc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_pre,
  input  logic             tick_edge,
  input  logic             en,
  input  logic             wr_reload,
  input  logic             wr_mode,
  input  logic [CNT_W-1:0] wr_data,
  output logic             fire_pre,
  output logic             fire_edge
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, rel_d, c1, s1, s2;
  logic             pend_q, pend_d, p1;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] r,
                                            input logic             p);
    logic [CNT_W-1:0] n;
    if (p)            n = (r <= CNT_W'(1)) ? r + CNT_W'(1) : r + CNT_W'(2);
    else if (c == '0) n = r + CNT_W'(1);
    else              n = c;
    return n - CNT_W'(1);
  endfunction

  always_comb begin
    s1        = step(cnt_q, rel_q, pend_q);
    c1        = tick_pre ? s1 : cnt_q;
    p1        = tick_pre ? 1'b0 : pend_q;
    s2        = step(c1, rel_q, p1);
    cnt_d     = tick_edge ? s2 : c1;
    pend_d    = (tick_edge ? 1'b0 : p1) | wr_mode;
    rel_d     = wr_reload ? wr_data : rel_q;
    fire_pre  = tick_pre  & en & (s1 == '0);
    fire_edge = tick_edge & en & (s2 == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rel_q  <= rel_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irqc_delay.sv
module irqc_delay #(
  parameter int DLY_W    = 2,
  parameter int EDGE_DLY = 2,
  parameter int PRE_DLY  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ce,
  input  logic fire_pre,
  input  logic fire_edge,
  input  logic wr_dis,
  input  logic wr_ena,
  output logic en_q,
  output logic irq_q
);
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             irq_d, en_d;

  always_comb begin
    dly_d = dly_q;
    irq_d = irq_q;
    en_d  = en_q;
    if (cpu_ce && dly_q != '0) begin
      dly_d = dly_q - DLY_W'(1);
      if (dly_q == DLY_W'(1)) irq_d = 1'b1;
    end
    if (fire_edge)     dly_d = DLY_W'(EDGE_DLY);
    else if (fire_pre) dly_d = DLY_W'(PRE_DLY);
    if (wr_dis) begin
      en_d  = 1'b0;
      irq_d = 1'b0;
    end else if (wr_ena) begin
      en_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      irq_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      dly_q <= dly_d;
      irq_q <= irq_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/dual_src_irq_counter.sv
module dual_src_irq_counter
  import irqc_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                CNT_W    = 8,
  parameter int                PRE_W    = 2,
  parameter int                EDGE_DLY = 2,
  parameter int                PRE_DLY  = 1,
  parameter logic [ADDR_W-1:0] DEC_MASK = 16'hE001,
  parameter logic [ADDR_W-1:0] A_RELOAD = 16'hC000,
  parameter logic [ADDR_W-1:0] A_MODE   = 16'hC001,
  parameter logic [ADDR_W-1:0] A_DIS    = 16'hE000,
  parameter logic [ADDR_W-1:0] A_EN     = 16'hE001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic              vaddr_rise,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              irq
);
  localparam int DLY_MAX = (EDGE_DLY > PRE_DLY) ? EDGE_DLY : PRE_DLY;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);

  logic [1:0] rsync_q;
  logic       rst_int_n;
  wr_kind_e   kind;
  logic       mode_q, tick_pre, tick_edge, fire_pre, fire_edge, en_q;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  irqc_decode #(
    .ADDR_W(ADDR_W), .DEC_MASK(DEC_MASK), .A_RELOAD(A_RELOAD),
    .A_MODE(A_MODE), .A_DIS(A_DIS), .A_EN(A_EN)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .kind(kind)
  );

  irqc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .cpu_ce(cpu_ce),
    .wr_mode(kind == WK_MODE), .wr_bit0(wr_data[0]),
    .mode_q(mode_q), .tick(tick_pre)
  );

  // Edge pulses count only while the prescaler source is not selected.
  assign tick_edge = vaddr_rise & ~mode_q;

  irqc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick_pre(tick_pre), .tick_edge(tick_edge),
    .en(en_q), .wr_reload(kind == WK_RELOAD), .wr_mode(kind == WK_MODE),
    .wr_data(wr_data), .fire_pre(fire_pre), .fire_edge(fire_edge)
  );

  irqc_delay #(.DLY_W(DLY_W), .EDGE_DLY(EDGE_DLY), .PRE_DLY(PRE_DLY)) u_dly (
    .clk(clk), .rst_n(rst_int_n), .cpu_ce(cpu_ce),
    .fire_pre(fire_pre), .fire_edge(fire_edge),
    .wr_dis(kind == WK_DISABLE), .wr_ena(kind == WK_ENABLE),
    .en_q(en_q), .irq_q(irq)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] DEC_MASK = 16'hE001,
  parameter logic [ADDR_W-1:0] A_DIS    = 16'hE000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ce,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq,
  input logic              mode,
  input logic              tick_pre,
  input logic              fire_edge
);
  logic ack_wr;
  assign ack_wr = wr_en && ((wr_addr & DEC_MASK) == A_DIS);

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> !irq);

  // R9
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_wr) |=> irq);

  // R5
  rise_on_cpu_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cpu_ce));

  // R6
  no_edge_in_cycle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> !fire_edge);

  // R6
  prescale_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pre |=> !tick_pre);
endmodule

bind dual_src_irq_counter irqc_chk #(
  .ADDR_W(ADDR_W), .DEC_MASK(DEC_MASK), .A_DIS(A_DIS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
  .wr_addr(wr_addr), .irq(irq), .mode(mode_q),
  .tick_pre(tick_pre), .fire_edge(fire_edge)
);

// File: tb/test_dual_src_irq_counter.sv
module test_dual_src_irq_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_ce = 1'b0;
  logic        vaddr_rise = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [15:0] RLD = 16'hC000, MOD = 16'hC001, DIS = 16'hE000, ENA = 16'hE001;

  always #2 clk = ~clk;

  dual_src_irq_counter i_dual_src_irq_counter (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .vaddr_rise(vaddr_rise),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input logic ce, input logic ed, input logic w,
                     input logic [15:0] a, input logic [7:0] d);
    cpu_ce = ce; vaddr_rise = ed; wr_en = w; wr_addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic ce1();
    cyc(1'b1, 1'b0, 1'b0, 16'h0, 8'h0);
  endtask

  task automatic edge1();
    cyc(1'b0, 1'b1, 1'b0, 16'h0, 8'h0);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: irq actual %0b expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) ce1();
    check(irq, 1'b0, "R1 reset state");

    // R3 R4 R5: every reload value in edge mode
    for (int r = 0; r < 256; r++) begin
      int first;
      first = (r <= 1) ? r + 1 : r + 2;
      if (first > 255) first = first - 256;
      if (first == 0) first = 256;
      wr(DIS, 8'h0); wr(RLD, 8'(r)); wr(MOD, 8'h00); wr(ENA, 8'h0);
      repeat (first - 1) edge1();
      ce1(); ce1();
      check(irq, 1'b0, $sformatf("R3 early r=%0d", r));
      edge1(); ce1();
      check(irq, 1'b0, $sformatf("R5 edge delay r=%0d", r));
      ce1();
      check(irq, 1'b1, $sformatf("R3 first zero r=%0d", r));
      wr(DIS, 8'h0); wr(ENA, 8'h0);
      repeat (r) edge1();
      ce1(); ce1();
      check(irq, 1'b0, $sformatf("R4 early r=%0d", r));
      edge1(); ce1(); ce1();
      check(irq, 1'b1, $sformatf("R4 period r=%0d", r));
    end

    // R6 R2: CPU-cycle mode, edges held high, reload via mirror address
    for (int r = 0; r < 16; r++) begin
      int first;
      first = (r <= 1) ? r + 1 : r + 2;
      wr(DIS, 8'h0); wr(16'hC0FE, 8'(r)); wr(MOD, 8'h01); wr(ENA, 8'h0);
      repeat (4 * first) cyc(1'b1, 1'b1, 1'b0, 16'h0, 8'h0);
      check(irq, 1'b0, $sformatf("R6 early r=%0d", r));
      cyc(1'b1, 1'b1, 1'b0, 16'h0, 8'h0);
      check(irq, 1'b1, $sformatf("R6 R2 prescaled zero r=%0d", r));
    end

    // R7: one forced step after leaving CPU-cycle mode
    wr(DIS, 8'h0); wr(RLD, 8'h00); wr(MOD, 8'h01); wr(ENA, 8'h0);
    ce1(); ce1();
    wr(MOD, 8'h00);
    ce1(); ce1();
    check(irq, 1'b0, "R7 forced step delay");
    ce1();
    check(irq, 1'b1, "R7 forced step fires");
    wr(DIS, 8'h0); wr(ENA, 8'h0);
    repeat (12) ce1();
    check(irq, 1'b0, "R7 prescaler stopped");

    // R10: forced step and edge step in one cycle
    wr(DIS, 8'h0); wr(RLD, 8'h03); wr(MOD, 8'h01); wr(ENA, 8'h0);
    ce1(); ce1();
    wr(MOD, 8'h00);
    ce1();
    cyc(1'b1, 1'b1, 1'b0, 16'h0, 8'h0);
    edge1(); edge1(); ce1(); ce1();
    check(irq, 1'b0, "R10 early");
    edge1(); ce1(); ce1();
    check(irq, 1'b1, "R10 both steps taken");

    // R8: disabled zero schedules nothing
    wr(DIS, 8'h0); wr(RLD, 8'h00); wr(MOD, 8'h00);
    repeat (3) begin edge1(); ce1(); ce1(); end
    check(irq, 1'b0, "R8 disabled");
    wr(ENA, 8'h0);
    edge1(); ce1(); ce1();
    check(irq, 1'b1, "R8 enabled");

    // R9: level hold, ack priority, pending delay survives disable
    repeat (10) ce1();
    check(irq, 1'b1, "R9 held");
    wr(16'hFFFE, 8'h0);
    check(irq, 1'b0, "R9 mirror ack clears");
    wr(ENA, 8'h0);
    edge1(); ce1();
    cyc(1'b1, 1'b0, 1'b1, DIS, 8'h0);
    check(irq, 1'b0, "R9 ack wins over expiry");
    wr(ENA, 8'h0);
    edge1();
    wr(DIS, 8'h0);
    ce1();
    check(irq, 1'b0, "R9 pending early");
    ce1();
    check(irq, 1'b1, "R9 pending survives disable");
    wr(DIS, 8'h0);
    check(irq, 1'b0, "R9 final ack");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule